// File: doc/BRIEF.md
# LIN-capable UART transceiver

This block is a full-duplex asynchronous serial channel with a built-in baud-rate generator. A small register bus writes bytes to send, reads received bytes, sets the frame options and the bit rate, and reads and clears the status flags. The transmit side and the receive side each have a holding register in front of the shift register. Software can therefore queue the next byte while the current one is on the wire, and it has one full frame time to collect a received byte before the next one arrives.

When the LIN option is on, software can ask for a break sequence. The line is held low for 13 to 16 bit times and then held high for a delimiter of 1 to 4 bit times. After that, queued bytes go out as ordinary frames. The receiver checks each frame and reports a parity error, a framing error and an overrun in separate sticky flags. These flags, together with "byte waiting", drive a single interrupt line.

Bit timing: the baud generator gives one tick every `divisor+1` clocks, and one bit lasts `OS` ticks (16 by default). A frame is one low start bit, 8 data bits sent LSB first, an optional even-parity bit and one high stop bit.

Top module: `lin_uart`

## Requirements
- R1: After reset, `txd` is 1, `irq` is 0 and the status register (address 3) reads 0x0003: bit 0 "transmit holding register empty" = 1, bit 1 "transmitter idle" = 1, and all other bits 0.
- R2: A byte written to address 0 is sent as a frame: a low start bit, then the 8 data bits LSB first, then a high stop bit. Each bit lasts 16 × (divisor+1) clocks.
- R3: When control bit 0 is 1, an even-parity bit (the XOR of the 8 data bits) is sent between the last data bit and the stop bit. When control bit 0 is 0, no parity bit is sent.
- R4: The baud generator produces a one-clock tick every (divisor+1) clocks. The divisor is written at address 2. All bit durations are whole multiples of this tick period.
- R5: The transmit holding register empties as soon as the shifter takes the byte (status bit 0 returns to 1 while status bit 1 is still 0). A second byte written at that point is sent right after the first, and both bytes arrive intact.
- R6: A received frame places its byte in the read side of address 0 and sets status bit 2. A read of address 0 with `reg_rd` high clears status bit 2.
- R7: If parity is enabled and the received parity bit differs from the XOR of the received data bits, status bit 3 is set.
- R8: A stop bit sampled low sets status bit 4. A line held low for a whole frame is received as byte 0x00 with status bit 4 set.
- R9: If a frame completes while status bit 2 is still set, status bit 5 is set and the new byte is discarded, so the earlier byte stays readable. Status bits 3 to 6 stay set until a write to address 3 with a 1 in the matching position.
- R10: With control bit 1 (LIN) set, writing address 3 with bit 7 set starts a break. During the break, `txd` is low for exactly (13 + control[3:2]) × 16 × (divisor+1) clocks.
- R11: After the break, `txd` stays high for (1 + control[5:4]) bit times. At the end of this delimiter, status bit 6 is set. Status bit 6 is cleared when a new break is accepted or when it is cleared by a write.
- R12: A break request is ignored unless the transmitter is idle (no frame in progress and no byte waiting in the holding register). An ignored request never drives the line low and never sets status bit 6.
- R13: `irq` is high exactly when any of status bits 2, 3, 4 or 5 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 0 takes the received byte) |
| reg_addr | input | 2 | Register address: 0 data, 1 control, 2 divisor, 3 status/command |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line |
| irq | output | 1 | Interrupt: received byte waiting or any error flag |

## Verification
The bench builds the block with an 8-bit divisor and 16 ticks per bit. With a divisor of 0 a bit lasts 16 clocks, so a frame takes 160 to 176 clocks and many parity and data patterns run in a short time. A divisor of 2 then checks that the break and delimiter lengths scale with the baud tick to the exact clock. The transmit line is looped back to the receiver, so every sent byte is also checked on receipt, and a break comes back as a zero byte with a framing error. The bench can also drive the receive line directly, to produce bad parity and a low stop bit.

// File: rtl/lin_uart_pkg.sv
package lin_uart_pkg;

  localparam logic [1:0] ADR_DATA = 2'd0;
  localparam logic [1:0] ADR_CTRL = 2'd1;
  localparam logic [1:0] ADR_BAUD = 2'd2;
  localparam logic [1:0] ADR_STAT = 2'd3;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP, TX_BRK, TX_DELIM
  } tx_state_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HUNT
  } rx_state_t;

  function automatic logic even_parity(input logic [7:0] d);
    return ^d;
  endfunction

  function automatic logic [4:0] break_bits(input logic [1:0] sel);
    return 5'd13 + {3'd0, sel};
  endfunction

  function automatic logic [4:0] delim_bits(input logic [1:0] sel);
    return 5'd1 + {3'd0, sel};
  endfunction

endpackage

// File: rtl/lin_uart_baud.sv
module lin_uart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= divisor;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/lin_uart_tx.sv
module lin_uart_tx
  import lin_uart_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       parity_en,
  input  logic       hold_wr,
  input  logic [7:0] hold_data,
  input  logic       brk_req,
  input  logic [1:0] brk_sel,
  input  logic [1:0] dlm_sel,
  output logic       txd,
  output logic       hold_empty,
  output logic       idle,
  output logic       brk_active,
  output logic       brk_fin
);

  localparam int SUB_W = $clog2(OS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OS - 1);

  tx_state_t        st;
  logic [SUB_W-1:0] sub;
  logic [4:0]       bitn;
  logic [7:0]       shr;
  logic [7:0]       hold;
  logic             hold_full;
  logic             pbit;
  logic             brk_pend;
  logic             bit_end;

  assign bit_end    = tick && (sub == SUB_LAST);
  assign hold_empty = !hold_full;
  assign idle       = (st == TX_IDLE) && !hold_full && !brk_pend;
  assign brk_active = (st == TX_BRK);
  assign brk_fin    = (st == TX_DELIM) && bit_end && (bitn == delim_bits(dlm_sel));

  always_comb begin
    case (st)
      TX_START, TX_BRK: txd = 1'b0;
      TX_DATA:          txd = shr[0];
      TX_PAR:           txd = pbit;
      default:          txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= TX_IDLE;
      sub       <= '0;
      bitn      <= '0;
      shr       <= '0;
      hold      <= '0;
      hold_full <= 1'b0;
      pbit      <= 1'b0;
      brk_pend  <= 1'b0;
    end else begin
      if (tick) sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
      case (st)
        TX_IDLE: begin
          if (tick) begin
            sub <= '0;
            if (brk_pend) begin
              st       <= TX_BRK;
              bitn     <= 5'd1;
              brk_pend <= 1'b0;
            end else if (hold_full) begin
              st        <= TX_START;
              shr       <= hold;
              pbit      <= even_parity(hold);
              hold_full <= 1'b0;
            end
          end
        end
        TX_START: if (bit_end) begin
          st   <= TX_DATA;
          bitn <= 5'd1;
        end
        TX_DATA: if (bit_end) begin
          shr <= {1'b0, shr[7:1]};
          if (bitn == 5'd8) st <= parity_en ? TX_PAR : TX_STOP;
          else              bitn <= bitn + 1'b1;
        end
        TX_PAR:  if (bit_end) st <= TX_STOP;
        TX_STOP: if (bit_end) st <= TX_IDLE;
        TX_BRK: if (bit_end) begin
          if (bitn == break_bits(brk_sel)) begin
            st   <= TX_DELIM;
            bitn <= 5'd1;
          end else begin
            bitn <= bitn + 1'b1;
          end
        end
        TX_DELIM: if (bit_end) begin
          if (bitn == delim_bits(dlm_sel)) st <= TX_IDLE;
          else                             bitn <= bitn + 1'b1;
        end
        default: st <= TX_IDLE;
      endcase
      if (brk_req && idle) brk_pend <= 1'b1;
      if (hold_wr) begin
        hold      <= hold_data;
        hold_full <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lin_uart_rx.sv
module lin_uart_rx
  import lin_uart_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       parity_en,
  output logic       done,
  output logic [7:0] data,
  output logic       perr,
  output logic       ferr
);

  localparam int SUB_W = $clog2(OS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OS - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OS / 2 - 1);

  rx_state_t        st;
  logic [SUB_W-1:0] sub;
  logic [3:0]       bitn;
  logic [7:0]       shr;
  logic             s1, s2;
  logic             samp;

  assign samp = tick && (sub == SUB_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      st   <= RX_IDLE;
      sub  <= '0;
      bitn <= '0;
      shr  <= '0;
      done <= 1'b0;
      data <= '0;
      perr <= 1'b0;
      ferr <= 1'b0;
    end else begin
      s1   <= rxd;
      s2   <= s1;
      done <= 1'b0;
      if (tick) sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
      case (st)
        RX_IDLE: if (tick && !s2) begin
          st  <= RX_START;
          sub <= '0;
        end
        RX_START: if (tick && sub == SUB_MID) begin
          sub <= '0;
          if (!s2) begin
            st   <= RX_DATA;
            bitn <= '0;
            perr <= 1'b0;
          end else begin
            st <= RX_IDLE;
          end
        end
        RX_DATA: if (samp) begin
          shr <= {s2, shr[7:1]};
          if (bitn == 4'd7) st <= parity_en ? RX_PAR : RX_STOP;
          else              bitn <= bitn + 1'b1;
        end
        RX_PAR: if (samp) begin
          perr <= s2 ^ even_parity(shr);
          st   <= RX_STOP;
        end
        RX_STOP: if (samp) begin
          done <= 1'b1;
          data <= shr;
          ferr <= !s2;
          st   <= s2 ? RX_IDLE : RX_HUNT;
        end
        RX_HUNT: if (s2) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lin_uart.sv
module lin_uart
  import lin_uart_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OS    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        txd,
  input  logic        rxd,
  output logic        irq
);

  logic [5:0]       ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       rbr;
  logic             rx_full, perr_q, ferr_q, ovr_q, brk_done;

  logic             tick_w;
  logic             hold_empty_w, tx_idle_w, brk_active_w, brk_fin_w;
  logic             rx_done_w, rx_perr_w, rx_ferr_w;
  logic [7:0]       rx_byte_w;
  logic             rx_pop_w, hold_wr_w, brk_req_w, stat_wr_w, brk_take_w;

  assign rx_pop_w   = reg_rd && (reg_addr == ADR_DATA);
  assign hold_wr_w  = reg_wr && (reg_addr == ADR_DATA);
  assign stat_wr_w  = reg_wr && (reg_addr == ADR_STAT);
  assign brk_req_w  = stat_wr_w && reg_wdata[7] && ctrl_q[1];
  assign brk_take_w = brk_req_w && tx_idle_w;

  lin_uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor(div_q), .tick(tick_w)
  );

  lin_uart_tx #(.OS(OS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .parity_en(ctrl_q[0]),
    .hold_wr(hold_wr_w), .hold_data(reg_wdata[7:0]), .brk_req(brk_req_w),
    .brk_sel(ctrl_q[3:2]), .dlm_sel(ctrl_q[5:4]), .txd(txd),
    .hold_empty(hold_empty_w), .idle(tx_idle_w), .brk_active(brk_active_w),
    .brk_fin(brk_fin_w)
  );

  lin_uart_rx #(.OS(OS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .rxd(rxd), .parity_en(ctrl_q[0]),
    .done(rx_done_w), .data(rx_byte_w), .perr(rx_perr_w), .ferr(rx_ferr_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      div_q    <= '0;
      rbr      <= '0;
      rx_full  <= 1'b0;
      perr_q   <= 1'b0;
      ferr_q   <= 1'b0;
      ovr_q    <= 1'b0;
      brk_done <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADR_CTRL) ctrl_q <= reg_wdata[5:0];
      if (reg_wr && reg_addr == ADR_BAUD) div_q  <= DIV_W'(reg_wdata);
      if (stat_wr_w) begin
        if (reg_wdata[3]) perr_q   <= 1'b0;
        if (reg_wdata[4]) ferr_q   <= 1'b0;
        if (reg_wdata[5]) ovr_q    <= 1'b0;
        if (reg_wdata[6]) brk_done <= 1'b0;
      end
      if (brk_take_w) brk_done <= 1'b0;
      if (brk_fin_w)  brk_done <= 1'b1;
      if (rx_pop_w)   rx_full  <= 1'b0;
      if (rx_done_w) begin
        if (rx_full && !rx_pop_w) begin
          ovr_q <= 1'b1;
        end else begin
          rbr     <= rx_byte_w;
          rx_full <= 1'b1;
          if (rx_perr_w) perr_q <= 1'b1;
          if (rx_ferr_w) ferr_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      ADR_DATA: reg_rdata = {8'h00, rbr};
      ADR_CTRL: reg_rdata = {10'h000, ctrl_q};
      ADR_BAUD: reg_rdata = 16'(div_q);
      default:  reg_rdata = {9'h000, brk_done, ovr_q, ferr_q, perr_q,
                             rx_full, tx_idle_w, hold_empty_w};
    endcase
  end

  assign irq = rx_full | perr_q | ferr_q | ovr_q;

endmodule

// File: rtl/lin_uart_chk.sv
module lin_uart_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [DIV_W-1:0] divisor,
  input logic             rx_done,
  input logic             rx_full,
  input logic             rx_pop,
  input logic             ovr,
  input logic [7:0]       rbr,
  input logic             brk_done,
  input logic             brk_fin,
  input logic             tx_idle,
  input logic             txd
);

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor != '0 && $stable(divisor)) |=> !tick);

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full && !rx_pop) |=> ovr);

  // R9
  rbr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_pop) |=> $stable(rbr));

  // R6
  full_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_full) |=> rx_full);

  // R11
  brk_done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_done) |-> $past(brk_fin));

  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> txd);

endmodule

bind lin_uart lin_uart_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .divisor(div_q),
  .rx_done(rx_done_w), .rx_full(rx_full), .rx_pop(rx_pop_w), .ovr(ovr_q),
  .rbr(rbr), .brk_done(brk_done), .brk_fin(brk_fin_w), .tx_idle(tx_idle_w),
  .txd(txd)
);

// File: tb/test_lin_uart.sv
module test_lin_uart;

  localparam int WD_LIMIT = 100000;
  localparam int NVEC = 6;
  // {parity enable, data byte}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b0, 8'h00}, {1'b0, 8'hA5}, {1'b1, 8'h01},
    {1'b1, 8'hFF}, {1'b1, 8'h80}, {1'b0, 8'h5A}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd3;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        txd, irq;
  logic        use_raw = 1'b0, raw_rx = 1'b1;
  logic        rxd;
  int          checks = 0, errors = 0, cyc = 0;

  assign rxd = use_raw ? raw_rx : txd;

  always #4 clk = ~clk;

  lin_uart #(.DIV_W(8), .OS(16)) i_lin_uart (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .txd(txd), .rxd(rxd), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      errors = errors + 1;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic ones_odd(input logic [7:0] d);
    int n = 0;
    for (int i = 0; i < 8; i++) if (d[i]) n++;
    return (n % 2) == 1;
  endfunction

  task automatic check(input logic ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = 2'd3;
  endtask

  task automatic wait_stat(input int b, input logic v);
    @(negedge clk);
    reg_addr = 2'd3;
    #1;
    while (reg_rdata[b] !== v) begin
      @(negedge clk);
      #1;
    end
  endtask

  // Decodes one frame from txd at 16 clocks per bit (divisor 0).
  task automatic decode(input logic pen, output logic [7:0] d, output logic pb,
                        output logic stopb, output logic startb);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    repeat (7) @(negedge clk);
    startb = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (16) @(negedge clk);
      d[i] = txd;
    end
    pb = 1'b0;
    if (pen) begin
      repeat (16) @(negedge clk);
      pb = txd;
    end
    repeat (16) @(negedge clk);
    stopb = txd;
  endtask

  task automatic send_raw(input logic [7:0] d, input logic pen, input logic pb,
                          input logic stopb);
    logic [10:0] bits;
    int n;
    bits = {1'b1, stopb, pb, d, 1'b0};
    if (!pen) bits = {1'b1, 1'b1, stopb, d, 1'b0};
    n = pen ? 11 : 10;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      raw_rx = bits[i];
      repeat (15) @(negedge clk);
    end
    @(negedge clk);
    raw_rx = 1'b1;
    repeat (32) @(negedge clk);
  endtask

  task automatic measure_break(input int exp_lo, input int exp_hi, input string tag);
    int lo = 0, hi = 0;
    reg_addr = 2'd3;
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    while (txd === 1'b0) begin lo++; @(negedge clk); end
    while (reg_rdata[6] !== 1'b1) begin hi++; @(negedge clk); end
    check(lo == exp_lo, {tag, " R10 break low clocks"}, 16'(lo), 16'(exp_lo));
    check(hi == exp_hi, {tag, " R11 delimiter clocks"}, 16'(hi), 16'(exp_hi));
  endtask

  initial begin
    logic [15:0] r;
    logic [7:0]  d, d2;
    logic        pb, sb, stb, pb2, sb2, stb2;
    int          lowcnt;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    check(reg_rdata == 16'h0003, "R1 status after reset", reg_rdata, 16'h0003);
    check(txd === 1'b1, "R1 txd idle high", {15'd0, txd}, 16'd1);
    check(irq === 1'b0, "R1 irq low", {15'd0, irq}, 16'd0);

    // Table walk: R2, R3, R6
    wr(2'd2, 16'd0);
    for (int v = 0; v < NVEC; v++) begin
      wr(2'd1, {15'd0, VEC[v][8]});
      wr(2'd0, {8'd0, VEC[v][7:0]});
      decode(VEC[v][8], d, pb, sb, stb);
      check(stb == 1'b0, "R2 start bit low", {15'd0, stb}, 16'd0);
      check(d == VEC[v][7:0], "R2 data bits LSB first", {8'd0, d}, {8'd0, VEC[v][7:0]});
      check(sb == 1'b1, "R2 stop bit high", {15'd0, sb}, 16'd1);
      if (VEC[v][8])
        check(pb == ones_odd(VEC[v][7:0]), "R3 even parity bit", {15'd0, pb},
              {15'd0, ones_odd(VEC[v][7:0])});
      wait_stat(2, 1'b1);
      check(reg_rdata[5:3] == 3'b000, "R6 no error flags", {13'd0, reg_rdata[5:3]}, 16'd0);
      check(irq === 1'b1, "R13 irq with byte waiting", {15'd0, irq}, 16'd1);
      rd(2'd0, r);
      check(r == {8'd0, VEC[v][7:0]}, "R6 received byte", r, {8'd0, VEC[v][7:0]});
      #1;
      check(reg_rdata[2] == 1'b0, "R6 read clears full", {15'd0, reg_rdata[2]}, 16'd0);
    end

    // R5 double buffering
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0096);
    wait_stat(0, 1'b1);
    check(reg_rdata[1] == 1'b0, "R5 holding empty while busy", {15'd0, reg_rdata[1]}, 16'd0);
    wr(2'd0, 16'h0069);
    #1;
    check(reg_rdata[0] == 1'b0, "R5 holding refilled", {15'd0, reg_rdata[0]}, 16'd0);
    fork
      begin
        decode(1'b0, d, pb, sb, stb);
        decode(1'b0, d2, pb2, sb2, stb2);
        check(d == 8'h96, "R5 first frame", {8'd0, d}, 16'h0096);
        check(d2 == 8'h69, "R5 second frame", {8'd0, d2}, 16'h0069);
      end
      begin
        logic [15:0] q;
        wait_stat(2, 1'b1);
        rd(2'd0, q);
        check(q == 16'h0096, "R5 first byte received", q, 16'h0096);
        wait_stat(2, 1'b1);
        rd(2'd0, q);
        check(q == 16'h0069, "R5 second byte received", q, 16'h0069);
      end
    join

    // R9 overrun
    wr(2'd0, 16'h0011);
    wait_stat(2, 1'b1);
    wr(2'd0, 16'h0022);
    wait_stat(1, 1'b1);
    repeat (20) @(negedge clk);
    #1;
    check(reg_rdata[5] == 1'b1, "R9 overrun flag set", {15'd0, reg_rdata[5]}, 16'd1);
    check(irq === 1'b1, "R13 irq on overrun", {15'd0, irq}, 16'd1);
    rd(2'd0, r);
    check(r == 16'h0011, "R9 earlier byte kept", r, 16'h0011);
    #1;
    check(reg_rdata[5] == 1'b1, "R9 overrun sticky after read", {15'd0, reg_rdata[5]}, 16'd1);
    wr(2'd3, 16'h0020);
    #1;
    check(reg_rdata[5] == 1'b0, "R9 overrun cleared by write", {15'd0, reg_rdata[5]}, 16'd0);
    check(irq === 1'b0, "R13 irq low when clear", {15'd0, irq}, 16'd0);

    // R7 parity error, driven on the receive line
    use_raw = 1'b1;
    wr(2'd1, 16'h0001);
    send_raw(8'h01, 1'b1, 1'b0, 1'b1);
    #1;
    check(reg_rdata[3] == 1'b1, "R7 parity error flag", {15'd0, reg_rdata[3]}, 16'd1);
    check(reg_rdata[4] == 1'b0, "R7 no framing error", {15'd0, reg_rdata[4]}, 16'd0);
    rd(2'd0, r);
    check(r == 16'h0001, "R7 byte with bad parity", r, 16'h0001);
    wr(2'd3, 16'h0078);

    // R8 framing error
    wr(2'd1, 16'h0000);
    send_raw(8'hC3, 1'b0, 1'b0, 1'b0);
    #1;
    check(reg_rdata[4] == 1'b1, "R8 framing error flag", {15'd0, reg_rdata[4]}, 16'd1);
    rd(2'd0, r);
    check(r == 16'h00C3, "R8 byte with low stop", r, 16'h00C3);
    wr(2'd3, 16'h0078);
    use_raw = 1'b0;

    // R10/R11 break, divisor 2: 15 bits low, 4 bits delimiter
    wr(2'd2, 16'd2);
    wr(2'd1, 16'h003A);
    wr(2'd3, 16'h0080);
    measure_break(15 * 16 * 3, 4 * 16 * 3, "div2");
    #1;
    check(reg_rdata[4] == 1'b1, "R8 break received as framing error", {15'd0, reg_rdata[4]}, 16'd1);
    rd(2'd0, r);
    check(r == 16'h0000, "R8 break received as zero", r, 16'h0000);
    wr(2'd3, 16'h0078);
    #1;
    check(reg_rdata[6] == 1'b0, "R11 done cleared by write", {15'd0, reg_rdata[6]}, 16'd0);

    // Break, divisor 0: 13 bits low, 1 bit delimiter
    wr(2'd2, 16'd0);
    wr(2'd1, 16'h0002);
    wr(2'd3, 16'h0080);
    measure_break(13 * 16, 16, "div0");
    rd(2'd0, r);
    wr(2'd3, 16'h0078);

    // R12 break request while busy is ignored
    wr(2'd0, 16'h003C);
    wr(2'd3, 16'h0080);
    decode(1'b0, d, pb, sb, stb);
    check(d == 8'h3C, "R12 frame after ignored break", {8'd0, d}, 16'h003C);
    wait_stat(2, 1'b1);
    check(reg_rdata[4] == 1'b0, "R12 no break seen", {15'd0, reg_rdata[4]}, 16'd0);
    rd(2'd0, r);
    check(r == 16'h003C, "R12 byte intact", r, 16'h003C);
    lowcnt = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lowcnt++;
    end
    #1;
    check(lowcnt == 0, "R12 line stays high", 16'(lowcnt), 16'd0);
    check(reg_rdata[6] == 1'b0, "R12 break done not set", {15'd0, reg_rdata[6]}, 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule